// File: doc/BRIEF.md
# Two-Group Level Interrupt Controller

This block merges two groups of level-sensitive interrupt lines, a wide peripheral group of 64 lines and a narrow local group of 8 lines, into a normal interrupt request and a fast interrupt request. Every line is sampled into a flop on each clock, with no reset on those flops. A mask is kept for each line. The normal request is the OR of all lines that are both high and unmasked.

Software sets mask bits by writing ones to a set register and clears them by writing ones to a separate clear register. Because of this, no read-modify-write is ever needed. Three read-only status words report the masked pending state. One is for peripheral lines 0..31 and one is for lines 32..63. The third is a summary word that combines the local lines, a per-half "any pending" flag, and copies of eleven chosen peripheral lines, so a handler can often resolve the cause with a single read.

Any one line can be steered straight to the fast output, bypassing the masks. Access is through a simple 32-bit bus with valid, write, a 9-bit byte offset and write data. Read data comes back one cycle after the request.

Top module: `irqc_top`

## Requirements
- R1: Reset (rst_ni low) clears both masks, the fast enable and the fast select. irq_o and fast_irq_o are low while reset is held and after it is released. The sampled line levels are not cleared by reset.
- R2: Mask set registers: a write ORs its ones into the mask. 0x010 covers lines 0..31 (data bit n is line n), 0x014 covers lines 32..63 (data bit n is line 32+n), and 0x018 covers local lines (only data bits 7:0 count). Reading any of these returns the current mask, zero-extended.
- R3: Mask clear registers 0x01C, 0x020 and 0x024 use the same bit layout. A write clears every mask bit written as one. Reading one returns the bitwise inverse of the matching mask across all 32 bits, so bits 31:8 of 0x024 read as ones.
- R4: 0x004 reads the line levels ANDed with the mask for lines 0..31. 0x008 does the same for lines 32..63.
- R5: Summary word at 0x000. Bits 7:0 are the masked local lines. Bit 8 is set if any masked line in 0..31 is pending. Bit 9 is set if any masked line in 32..63 is pending. Bits 10..20 carry the masked state of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62, in that order. Bits 31:21 read zero.
- R6: Fast control at 0x00C. Bits 6:0 hold the source select and bit 7 holds the enable. Reading returns the same layout with bits 31:8 zero.
- R7: With the fast enable set, fast_irq_o equals the sampled level of the selected line, regardless of any mask. Select 0..63 picks peripheral line n. Select 64..71 picks local line n-64.
- R8: fast_irq_o is low when the fast enable is clear, and also when the select is 72..127.
- R9: irq_o is high exactly when at least one peripheral or local line is both high and unmasked.
- R10: A read of any offset not listed above, or of one not a multiple of 4, returns zero. A write to such an offset changes nothing.
- R11: A read request yields bus_rvalid_o and its data on the next cycle, and bus_rvalid_o is high only then. irq_o and fast_irq_o reflect a line change or a register write one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| periph_irq_i | input | 64 | Peripheral interrupt levels |
| local_irq_i | input | 8 | Local interrupt levels |
| bus_valid_i | input | 1 | Access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 9 | Byte offset in the 0x200 window |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| bus_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Normal interrupt request |
| fast_irq_o | output | 1 | Fast interrupt request |

## Verification
The bench targets cases where a plausible mistake stays hidden until a specific pattern appears:
- Writing two set values in a row exposes a set register that overwrites the mask instead of ORing into it.
- A high local select exposes fast routing that forgets the 64 offset.
- Selects of 72 and 127 with the enable set catch a router that wraps or indexes out of range and raises fast_irq_o falsely.
- The summary word is checked with mirrored lines in both halves and at the ends of the list (7 and 62), so a shifted or reordered mirror shows up as moved bits.
- The local clear read is checked for ones in bits 31:8, and misaligned and unlisted writes are followed by mask reads that would reveal any stray update.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned OFF_W = 9;
  typedef logic [OFF_W-1:0] off_t;

  localparam off_t OFF_SUMMARY = 9'h000;
  localparam off_t OFF_PEND_LO = 9'h004;
  localparam off_t OFF_PEND_HI = 9'h008;
  localparam off_t OFF_FAST    = 9'h00C;
  localparam off_t OFF_SET_LO  = 9'h010;
  localparam off_t OFF_SET_HI  = 9'h014;
  localparam off_t OFF_SET_LCL = 9'h018;
  localparam off_t OFF_CLR_LO  = 9'h01C;
  localparam off_t OFF_CLR_HI  = 9'h020;
  localparam off_t OFF_CLR_LCL = 9'h024;

  // Summary word: mirrored peripheral lines start at this bit
  localparam int unsigned MIRROR_N   = 11;
  localparam int unsigned MIRROR_LSB = 10;

  function automatic int unsigned mirror_src(input int unsigned idx);
    case (idx)
      0:       return 7;
      1:       return 9;
      2:       return 10;
      3:       return 18;
      4:       return 19;
      5:       return 53;
      6:       return 54;
      7:       return 55;
      8:       return 56;
      9:       return 57;
      default: return 62;
    endcase
  endfunction
endpackage

// File: rtl/irqc_level_store.sv
module irqc_level_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] lvl_o
);
  // Levels are deliberately outside the reset domain
  logic [W-1:0] lvl_q;
  always_ff @(posedge clk_i) lvl_q <= lvl_i;
  assign lvl_o = lvl_q;
endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
#(
  parameter int unsigned N_PERIPH = 64,
  parameter int unsigned N_LOCAL  = 8,
  parameter int unsigned DW       = 32,
  parameter int unsigned SEL_W    = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  off_t                wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  output logic [N_PERIPH-1:0] periph_mask_o,
  output logic [N_LOCAL-1:0]  local_mask_o,
  output logic                fast_en_o,
  output logic [SEL_W-1:0]    fast_sel_o
);
  localparam int unsigned N_WORDS = N_PERIPH / DW;

  logic [N_PERIPH-1:0] pmask_q, pmask_d;
  logic [N_LOCAL-1:0]  lmask_q, lmask_d;
  logic                fast_en_q;
  logic [SEL_W-1:0]    fast_sel_q;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    localparam off_t SET_A = OFF_SET_LO + OFF_W'(4 * w);
    localparam off_t CLR_A = OFF_CLR_LO + OFF_W'(4 * w);
    logic hit_set, hit_clr;
    assign hit_set = wr_en_i && (wr_addr_i == SET_A);
    assign hit_clr = wr_en_i && (wr_addr_i == CLR_A);
    assign pmask_d[w*DW +: DW] =
      hit_set ? (pmask_q[w*DW +: DW] |  wr_data_i) :
      hit_clr ? (pmask_q[w*DW +: DW] & ~wr_data_i) :
                 pmask_q[w*DW +: DW];
  end

  always_comb begin
    lmask_d = lmask_q;
    if (wr_en_i && wr_addr_i == OFF_SET_LCL) lmask_d = lmask_q |  wr_data_i[N_LOCAL-1:0];
    if (wr_en_i && wr_addr_i == OFF_CLR_LCL) lmask_d = lmask_q & ~wr_data_i[N_LOCAL-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pmask_q    <= '0;
      lmask_q    <= '0;
      fast_en_q  <= 1'b0;
      fast_sel_q <= '0;
    end else begin
      pmask_q <= pmask_d;
      lmask_q <= lmask_d;
      if (wr_en_i && wr_addr_i == OFF_FAST) begin
        fast_sel_q <= wr_data_i[SEL_W-1:0];
        fast_en_q  <= wr_data_i[SEL_W];
      end
    end
  end

  assign periph_mask_o = pmask_q;
  assign local_mask_o  = lmask_q;
  assign fast_en_o     = fast_en_q;
  assign fast_sel_o    = fast_sel_q;
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
  import irqc_pkg::*;
#(
  parameter int unsigned N_PERIPH = 64,
  parameter int unsigned N_LOCAL  = 8,
  parameter int unsigned DW       = 32
) (
  input  logic [N_PERIPH-1:0] periph_lvl_i,
  input  logic [N_LOCAL-1:0]  local_lvl_i,
  input  logic [N_PERIPH-1:0] periph_mask_i,
  input  logic [N_LOCAL-1:0]  local_mask_i,
  output logic [N_PERIPH-1:0] periph_pend_o,
  output logic [N_LOCAL-1:0]  local_pend_o,
  output logic [DW-1:0]       summary_o,
  output logic                irq_o
);
  localparam int unsigned N_WORDS = N_PERIPH / DW;

  assign periph_pend_o = periph_lvl_i & periph_mask_i;
  assign local_pend_o  = local_lvl_i & local_mask_i;

  always_comb begin
    summary_o = '0;
    summary_o[N_LOCAL-1:0] = local_pend_o;
    for (int w = 0; w < N_WORDS; w++)
      summary_o[N_LOCAL + w] = |periph_pend_o[w*DW +: DW];
    for (int m = 0; m < MIRROR_N; m++)
      summary_o[MIRROR_LSB + m] = periph_pend_o[mirror_src(m)];
  end

  assign irq_o = (|periph_pend_o) || (|local_pend_o);
endmodule

// File: rtl/irqc_fast_route.sv
module irqc_fast_route #(
  parameter int unsigned N_PERIPH = 64,
  parameter int unsigned N_LOCAL  = 8,
  parameter int unsigned SEL_W    = 7
) (
  input  logic                fast_en_i,
  input  logic [SEL_W-1:0]    fast_sel_i,
  input  logic [N_PERIPH-1:0] periph_lvl_i,
  input  logic [N_LOCAL-1:0]  local_lvl_i,
  output logic                fast_o
);
  localparam int unsigned N_SRC = N_PERIPH + N_LOCAL;
  localparam int unsigned N_PAD = 2 ** SEL_W;

  // Pad to the full select range so out-of-range selects read zero
  logic [N_PAD-1:0] src_vec;
  always_comb begin
    src_vec = '0;
    src_vec[N_SRC-1:0] = {local_lvl_i, periph_lvl_i};
  end

  assign fast_o = fast_en_i && src_vec[fast_sel_i];
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned N_PERIPH = 64,
  parameter int unsigned N_LOCAL  = 8,
  parameter int unsigned DW       = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PERIPH-1:0] periph_irq_i,
  input  logic [N_LOCAL-1:0]  local_irq_i,
  input  logic                bus_valid_i,
  input  logic                bus_write_i,
  input  logic [OFF_W-1:0]    bus_addr_i,
  input  logic [DW-1:0]       bus_wdata_i,
  output logic                bus_rvalid_o,
  output logic [DW-1:0]       bus_rdata_o,
  output logic                irq_o,
  output logic                fast_irq_o
);
  localparam int unsigned SEL_W = $clog2(N_PERIPH + N_LOCAL);

  logic [N_PERIPH-1:0] periph_lvl, periph_mask, periph_pend;
  logic [N_LOCAL-1:0]  local_lvl, local_mask, local_pend;
  logic [DW-1:0]       summary;
  logic                fast_en;
  logic [SEL_W-1:0]    fast_sel;
  logic                rd_en, wr_en;
  logic [DW-1:0]       rdata_d, rdata_q;
  logic                rvalid_q;

  assign rd_en = bus_valid_i && !bus_write_i;
  assign wr_en = bus_valid_i &&  bus_write_i;

  irqc_level_store #(.W(N_PERIPH)) u_periph_lvl (
    .clk_i(clk_i), .lvl_i(periph_irq_i), .lvl_o(periph_lvl)
  );
  irqc_level_store #(.W(N_LOCAL)) u_local_lvl (
    .clk_i(clk_i), .lvl_i(local_irq_i), .lvl_o(local_lvl)
  );

  irqc_regfile #(
    .N_PERIPH(N_PERIPH), .N_LOCAL(N_LOCAL), .DW(DW), .SEL_W(SEL_W)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en),
    .wr_addr_i    (bus_addr_i),
    .wr_data_i    (bus_wdata_i),
    .periph_mask_o(periph_mask),
    .local_mask_o (local_mask),
    .fast_en_o    (fast_en),
    .fast_sel_o   (fast_sel)
  );

  irqc_pending #(.N_PERIPH(N_PERIPH), .N_LOCAL(N_LOCAL), .DW(DW)) u_pend (
    .periph_lvl_i (periph_lvl),
    .local_lvl_i  (local_lvl),
    .periph_mask_i(periph_mask),
    .local_mask_i (local_mask),
    .periph_pend_o(periph_pend),
    .local_pend_o (local_pend),
    .summary_o    (summary),
    .irq_o        (irq_o)
  );

  irqc_fast_route #(.N_PERIPH(N_PERIPH), .N_LOCAL(N_LOCAL), .SEL_W(SEL_W)) u_fast (
    .fast_en_i   (fast_en),
    .fast_sel_i  (fast_sel),
    .periph_lvl_i(periph_lvl),
    .local_lvl_i (local_lvl),
    .fast_o      (fast_irq_o)
  );

  always_comb begin
    case (bus_addr_i)
      OFF_SUMMARY: rdata_d = summary;
      OFF_PEND_LO: rdata_d = periph_pend[DW-1:0];
      OFF_PEND_HI: rdata_d = periph_pend[2*DW-1:DW];
      OFF_FAST:    rdata_d = DW'({fast_en, fast_sel});
      OFF_SET_LO:  rdata_d = periph_mask[DW-1:0];
      OFF_SET_HI:  rdata_d = periph_mask[2*DW-1:DW];
      OFF_SET_LCL: rdata_d = DW'(local_mask);
      OFF_CLR_LO:  rdata_d = ~periph_mask[DW-1:0];
      OFF_CLR_HI:  rdata_d = ~periph_mask[2*DW-1:DW];
      OFF_CLR_LCL: rdata_d = ~DW'(local_mask);
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign bus_rvalid_o = rvalid_q;
  assign bus_rdata_o  = rdata_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int unsigned N_PERIPH = 64,
  parameter int unsigned N_LOCAL  = 8,
  parameter int unsigned DW       = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_valid_i,
  input logic                bus_write_i,
  input logic [OFF_W-1:0]    bus_addr_i,
  input logic [DW-1:0]       bus_wdata_i,
  input logic                bus_rvalid_o,
  input logic                irq_o,
  input logic                fast_irq_o,
  input logic [N_PERIPH-1:0] periph_mask_i,
  input logic [N_LOCAL-1:0]  local_mask_i
);
  AST_RSP_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i) |=> bus_rvalid_o); // R11

  AST_NO_STRAY_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_valid_i && !bus_write_i) |=> !bus_rvalid_o); // R11

  AST_SET_KEEPS_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && bus_addr_i == OFF_SET_LO)
    |=> ((periph_mask_i[DW-1:0] & $past(bus_wdata_i)) == $past(bus_wdata_i))); // R2

  AST_CLR_DROPS_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && bus_addr_i == OFF_CLR_LO)
    |=> ((periph_mask_i[DW-1:0] & $past(bus_wdata_i)) == '0)); // R3

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((|periph_mask_i) || (|local_mask_i))); // R9

  AST_FAST_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && bus_addr_i == OFF_FAST && !bus_wdata_i[7])
    |=> !fast_irq_o); // R8
endmodule

bind irqc_top irqc_checker #(.N_PERIPH(N_PERIPH), .N_LOCAL(N_LOCAL), .DW(DW)) u_irqc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rvalid_o (bus_rvalid_o),
  .irq_o        (irq_o),
  .fast_irq_o   (fast_irq_o),
  .periph_mask_i(periph_mask),
  .local_mask_i (local_mask)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] periph_irq;
  logic [7:0]  local_irq;
  logic        bus_valid, bus_write;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        irq, fast_irq;

  always #5 clk_i = ~clk_i;

  irqc_top u_irqc_top (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .periph_irq_i(periph_irq), .local_irq_i(local_irq),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rvalid_o(bus_rvalid), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .fast_irq_o(fast_irq)
  );

  int unsigned n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mon_exp;
  string       mon_tag;

  task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops an expectation for every response
  always @(negedge clk_i) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) compare("R11 response with no read", 32'd1, 32'd0);
      else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        compare(mon_tag, bus_rdata, mon_exp);
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_i);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk_i);
    bus_valid = 1'b0;
  endtask

  task automatic outs(input string tag, input logic e_irq, input logic e_fast);
    compare(tag, {30'd0, irq, fast_irq}, {30'd0, e_irq, e_fast});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL R11 watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    periph_irq = '0; local_irq = '0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk_i);
    outs("R1 outputs in reset", 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    outs("R1 outputs after reset", 1'b0, 1'b0);
    rd(9'h010, 32'h0, "R1 mask lo reset");
    rd(9'h014, 32'h0, "R1 mask hi reset");
    rd(9'h018, 32'h0, "R1 mask local reset");
    rd(9'h00C, 32'h0, "R1 fast ctrl reset");

    // lines 3,7,9,40,53,62 and local 0,2
    periph_irq = (64'd1 << 3) | (64'd1 << 7) | (64'd1 << 9) |
                 (64'd1 << 40) | (64'd1 << 53) | (64'd1 << 62);
    local_irq = 8'h05;
    @(negedge clk_i);
    outs("R9 all masked", 1'b0, 1'b0);
    rd(9'h004, 32'h0, "R4 pending lo masked");

    wr(9'h010, 32'h0000_0080);
    outs("R11 irq one edge after mask write", 1'b1, 1'b0);
    wr(9'h010, 32'h0000_0008);
    rd(9'h010, 32'h0000_0088, "R2 set ORs");
    rd(9'h004, 32'h0000_0088, "R4 pending lo");
    rd(9'h000, 32'h0000_0500, "R5 summary lo only");
    wr(9'h014, 32'h4020_0000);
    rd(9'h008, 32'h4020_0000, "R4 pending hi");
    rd(9'h000, 32'h0010_8700, "R5 summary both halves");
    wr(9'h018, 32'hFFFF_FF04);
    rd(9'h018, 32'h0000_0004, "R2 local set low byte only");
    rd(9'h000, 32'h0010_8704, "R5 summary with local");
    rd(9'h024, 32'hFFFF_FFFB, "R3 local clear read inverse");

    wr(9'h01C, 32'h0000_0080);
    rd(9'h010, 32'h0000_0008, "R3 clear lo");
    rd(9'h01C, 32'hFFFF_FFF7, "R3 clear lo read");
    rd(9'h020, 32'hBFDF_FFFF, "R3 clear hi read");
    rd(9'h000, 32'h0010_8304, "R5 summary mirror 7 gone");

    wr(9'h01C, 32'hFFFF_FFFF);
    wr(9'h020, 32'hFFFF_FFFF);
    outs("R9 local alone", 1'b1, 1'b0);
    wr(9'h024, 32'h0000_0004);
    outs("R9 nothing unmasked", 1'b0, 1'b0);
    rd(9'h000, 32'h0, "R5 summary empty");

    wr(9'h018, 32'h0000_0002);
    outs("R9 masked line low", 1'b0, 1'b0);
    local_irq = 8'h07;
    outs("R11 no change before edge", 1'b0, 1'b0);
    @(negedge clk_i);
    outs("R11 irq after line rise", 1'b1, 1'b0);
    local_irq = 8'h05;
    @(negedge clk_i);
    outs("R11 irq after line fall", 1'b0, 1'b0);
    wr(9'h024, 32'h0000_00FF);

    wr(9'h00C, 32'h0000_0089);
    outs("R7 fast line 9 unmasked", 1'b0, 1'b1);
    rd(9'h00C, 32'h0000_0089, "R6 fast readback");
    wr(9'h00C, 32'hFFFF_FF8A);
    outs("R7 fast line 10 low", 1'b0, 1'b0);
    rd(9'h00C, 32'h0000_008A, "R6 fast upper bits dropped");
    wr(9'h00C, 32'h0000_00C0);
    outs("R7 fast local 0", 1'b0, 1'b1);
    wr(9'h00C, 32'h0000_00C1);
    outs("R7 fast local 1 low", 1'b0, 1'b0);
    wr(9'h00C, 32'h0000_00C7);
    outs("R7 fast local 7 low", 1'b0, 1'b0);
    local_irq = 8'h85;
    @(negedge clk_i);
    outs("R7 fast local 7 high", 1'b0, 1'b1);
    wr(9'h00C, 32'h0000_00C8);
    outs("R8 select 72", 1'b0, 1'b0);
    wr(9'h00C, 32'h0000_00FF);
    outs("R8 select 127", 1'b0, 1'b0);
    wr(9'h00C, 32'h0000_0007);
    outs("R8 fast disabled", 1'b0, 1'b0);

    wr(9'h028, 32'hFFFF_FFFF);
    wr(9'h011, 32'hFFFF_FFFF);
    wr(9'h1FC, 32'hFFFF_FFFF);
    wr(9'h00D, 32'hFFFF_FFFF);
    outs("R10 stray writes no irq", 1'b0, 1'b0);
    rd(9'h010, 32'h0, "R10 mask lo untouched");
    rd(9'h014, 32'h0, "R10 mask hi untouched");
    rd(9'h018, 32'h0, "R10 mask local untouched");
    rd(9'h00C, 32'h0000_0007, "R10 fast untouched");
    rd(9'h028, 32'h0, "R10 unlisted read");
    rd(9'h1FC, 32'h0, "R10 top of window read");
    rd(9'h012, 32'h0, "R10 misaligned read");

    wr(9'h010, 32'hFFFF_FFFF);
    wr(9'h00C, 32'h0000_0083);
    outs("R7 fast line 3 before reset", 1'b1, 1'b1);
    rst_ni = 1'b0;
    @(negedge clk_i);
    outs("R1 reset mid run", 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(9'h010, 32'h0, "R1 mask cleared by reset");
    rd(9'h00C, 32'h0, "R1 fast cleared by reset");
    wr(9'h010, 32'h0000_0008);
    outs("R1 levels kept through reset", 1'b1, 1'b0);

    repeat (3) @(negedge clk_i);
    compare("R11 responses outstanding", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end
endmodule